// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the status-register slice of the slave logic in a serial flash device. It watches a mode-0 SPI bus: chip select is active low, and data-in is sampled on the rising serial clock. All three bus inputs are synchronised into the system clock domain before use. The block decodes five one-byte commands: two write-enable variants, a read of the low status byte, a read of the high status byte, and a status write. It holds a 16-bit status word. Bit 0 is the busy flag (write in progress) and bit 1 is the write-enable latch.

A read places the selected status byte on data-out, MSB first, and sets the output enable. It keeps repeating that byte for as long as chip select stays low. Each repeat takes a fresh copy of the status, so software can poll the busy flag in one transaction.

A status write is committed only when chip select rises right after 8 or 16 data bits and the latch is set. It then starts a self-timed busy period of `TW_CYCLES` system clocks. At the end of that period the latch clears. Bits 15, 10, 1 and 0 can never be set through write data.

Top module: `sfsr_top`

## Requirements
- R1: After reset every status bit is 0 and the output enable is low.
- R2: Opcode 0x05 returns status bits 7..0, MSB first. The first bit is driven after the falling clock that follows the 8th opcode bit.
- R3: Opcode 0x35 returns status bits 15..8, MSB first.
- R4: While chip select stays low after a read opcode, the selected byte repeats and is re-sampled at each byte start. The output enable is low whenever chip select is high, during opcode reception, and for every non-read command.
- R5: Opcode 0x06 or 0x50 sets bit 1 (write-enable latch) when chip select rises right after its 8 bits. Opcode 0x01 takes effect only if bit 1 is set when chip select rises.
- R6: A write of 8 data bits updates only the low byte. A write of 16 data bits updates the low byte from the first data byte and the high byte from the second.
- R7: Write data never changes bits 15, 10, 1 and 0.
- R8: A status write ended after any bit count other than 8 or 16 has no effect, and the write-enable latch stays as it was.
- R9: A committed write sets bit 0 for exactly `TW_CYCLES` system clocks. Status reads work normally during that time.
- R10: When the busy period ends, bits 0 and 1 both read 0.
- R11: While bit 0 is set, opcodes 0x06, 0x50 and 0x01 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for spi_miso; low means high impedance |

## Verification
Each bus input reaches the logic `SYNC_STAGES` plus one edge-detect register after it changes, and the data-out bit settles one clock later. So data-out is due about four system clocks after a falling serial clock. The bench holds each serial clock phase for eight system clocks and samples data-out at the next rising serial edge. A write commits within four clocks of chip select rising, and the bench waits several clocks before the next command. The busy flag is checked by a read issued well inside `TW_CYCLES`, and again after `TW_CYCLES` plus a margin. The exact length of the busy period is counted cycle by cycle in the bound checker.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_VWREN = 8'h50;
   localparam logic [7:0] OP_RDLO  = 8'h05;
   localparam logic [7:0] OP_RDHI  = 8'h35;
   localparam logic [7:0] OP_WRSR  = 8'h01;

   typedef enum logic [2:0] {
      PH_OPCODE,
      PH_ENABLE,
      PH_READ,
      PH_WRITE,
      PH_SKIP
   } phase_e;
endpackage

// File: rtl/sfsr_sync.sv
module sfsr_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else if (STAGES == 1) begin : g_single
         logic ff_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= RST_VAL;
            else        ff_q <= d;
         end
         assign q = ff_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], d};
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sfsr_timer.sv
module sfsr_timer #(
   parameter int TW_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(TW_CYCLES + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (start)         cnt_q <= CW'(TW_CYCLES);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
   assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/sfsr_status.sv
module sfsr_status #(
   parameter logic [15:0] PROTECT_MASK = 16'h8403
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        set_wel,
   input  logic        wr_start,
   input  logic        wr_wide,
   input  logic [15:0] wr_data,
   input  logic        done,
   input  logic        busy,
   output logic [15:0] status
);
   logic [15:0] regs_q;
   logic [15:0] wr_mask;
   logic [15:0] wr_val;

   always_comb begin
      wr_mask = ~PROTECT_MASK & (wr_wide ? 16'hFFFF : 16'h00FF);
      wr_val  = wr_wide ? {wr_data[7:0], wr_data[15:8]} : {8'h00, wr_data[7:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs_q <= '0;
      end else begin
         if (wr_start) regs_q <= (regs_q & ~wr_mask) | (wr_val & wr_mask);
         if (set_wel)  regs_q[1] <= 1'b1;
         if (done)     regs_q[1] <= 1'b0;
      end
   end

   assign status = {regs_q[15:1], busy};
endmodule

// File: rtl/sfsr_frame.sv
module sfsr_frame
   import sfsr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        csn_s,
   input  logic        csn_rise,
   input  logic        sck_rise,
   input  logic        sck_fall,
   input  logic        mosi_s,
   input  logic [15:0] status,
   input  logic        busy,
   output logic        set_wel,
   output logic        wr_start,
   output logic        wr_wide,
   output logic [15:0] wr_data,
   output logic        miso,
   output logic        miso_oe
);
   phase_e      phase_q;
   logic [4:0]  bit_cnt_q;
   logic [15:0] shreg_q;
   logic        sel_hi_q;
   logic [7:0]  out_byte_q;
   logic [2:0]  out_idx_q;
   logic        miso_q;
   logic        oe_q;
   logic [7:0]  op_byte;
   logic [7:0]  fresh_byte;

   assign op_byte    = {shreg_q[6:0], mosi_s};
   assign fresh_byte = sel_hi_q ? status[15:8] : status[7:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_OPCODE;
         bit_cnt_q  <= '0;
         shreg_q    <= '0;
         sel_hi_q   <= 1'b0;
         out_byte_q <= '0;
         out_idx_q  <= 3'd7;
         miso_q     <= 1'b0;
         oe_q       <= 1'b0;
      end else if (csn_s) begin
         phase_q   <= PH_OPCODE;
         bit_cnt_q <= '0;
         oe_q      <= 1'b0;
         out_idx_q <= 3'd7;
      end else begin
         if (sck_rise) begin
            shreg_q <= {shreg_q[14:0], mosi_s};
            if (bit_cnt_q != 5'h1F) bit_cnt_q <= bit_cnt_q + 1'b1;
            unique case (phase_q)
               PH_OPCODE: begin
                  if (bit_cnt_q == 5'd7) begin
                     bit_cnt_q <= '0;
                     if (op_byte == OP_RDLO || op_byte == OP_RDHI) begin
                        phase_q   <= PH_READ;
                        sel_hi_q  <= (op_byte == OP_RDHI);
                        oe_q      <= 1'b1;
                        out_idx_q <= 3'd7;
                     end else if ((op_byte == OP_WREN || op_byte == OP_VWREN) && !busy) begin
                        phase_q <= PH_ENABLE;
                     end else if (op_byte == OP_WRSR && !busy) begin
                        phase_q <= PH_WRITE;
                     end else begin
                        phase_q <= PH_SKIP;
                     end
                  end
               end
               PH_ENABLE: phase_q <= PH_SKIP;
               default: ;
            endcase
         end
         if (sck_fall && phase_q == PH_READ) begin
            if (out_idx_q == 3'd7) begin
               out_byte_q <= fresh_byte;
               miso_q     <= fresh_byte[7];
            end else begin
               miso_q <= out_byte_q[out_idx_q];
            end
            out_idx_q <= out_idx_q - 1'b1;
         end
      end
   end

   always_comb begin
      set_wel  = csn_rise && (phase_q == PH_ENABLE) && !busy;
      wr_wide  = (bit_cnt_q == 5'd16);
      wr_start = csn_rise && (phase_q == PH_WRITE) && !busy && status[1] &&
                 ((bit_cnt_q == 5'd8) || (bit_cnt_q == 5'd16));
      wr_data  = shreg_q;
   end

   assign miso    = miso_q;
   assign miso_oe = oe_q;
endmodule

// File: rtl/sfsr_top.sv
module sfsr_top #(
   parameter int          TW_CYCLES    = 1000,
   parameter int          SYNC_STAGES  = 2,
   parameter logic [15:0] PROTECT_MASK = 16'h8403
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_csn,
   input  logic spi_sck,
   input  logic spi_mosi,
   output logic spi_miso,
   output logic spi_miso_oe
);
   generate
      if (TW_CYCLES < 1) begin : g_bad_tw
         $error("sfsr_top: TW_CYCLES must be at least 1");
      end
      if (PROTECT_MASK[1:0] != 2'b11) begin : g_bad_mask
         $error("sfsr_top: PROTECT_MASK must cover bits 1 and 0");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("sfsr_top: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic        csn_s, sck_s, mosi_s;
   logic        csn_d, sck_d;
   logic        csn_rise, sck_rise, sck_fall;
   logic        set_wel, wr_start, wr_wide, done, busy;
   logic [15:0] wr_data;
   logic [15:0] status;

   sfsr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
      .clk(clk), .rst_n(rst_n), .d(spi_csn), .q(csn_s));
   sfsr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
      .clk(clk), .rst_n(rst_n), .d(spi_sck), .q(sck_s));
   sfsr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
      .clk(clk), .rst_n(rst_n), .d(spi_mosi), .q(mosi_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csn_d <= 1'b1;
         sck_d <= 1'b0;
      end else begin
         csn_d <= csn_s;
         sck_d <= sck_s;
      end
   end

   assign csn_rise = csn_s & ~csn_d;
   assign sck_rise = sck_s & ~sck_d & ~csn_s;
   assign sck_fall = ~sck_s & sck_d & ~csn_s;

   sfsr_frame u_frame (
      .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .csn_rise(csn_rise),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
      .status(status), .busy(busy), .set_wel(set_wel), .wr_start(wr_start),
      .wr_wide(wr_wide), .wr_data(wr_data), .miso(spi_miso), .miso_oe(spi_miso_oe));

   sfsr_status #(.PROTECT_MASK(PROTECT_MASK)) u_status (
      .clk(clk), .rst_n(rst_n), .set_wel(set_wel), .wr_start(wr_start),
      .wr_wide(wr_wide), .wr_data(wr_data), .done(done), .busy(busy),
      .status(status));

   sfsr_timer #(.TW_CYCLES(TW_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(wr_start), .busy(busy), .done(done));
endmodule

// File: rtl/sfsr_top_chk.sv
module sfsr_top_chk #(
   parameter int TW_CYCLES = 1000
) (
   input logic        clk,
   input logic        rst_n,
   input logic        csn_s,
   input logic        miso_oe,
   input logic        wr_start,
   input logic [15:0] status
);
   logic [31:0] run_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         run_cnt_q <= '0;
      else if (status[0]) run_cnt_q <= run_cnt_q + 1'b1;
      else                run_cnt_q <= '0;
   end

   AST_OE_OFF_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      csn_s |=> !miso_oe); // R4
   AST_WR_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |-> (status[1] && !status[0])); // R5
   AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |=> (status[15] == $past(status[15]) && status[10] == $past(status[10]))); // R7
   AST_WIP_START: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |=> status[0]); // R9
   AST_WIP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[0]) |-> (run_cnt_q == 32'(TW_CYCLES))); // R9
   AST_WEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[0]) |-> !status[1]); // R10
   AST_NO_ENABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[1]) |-> !$past(status[0])); // R11
endmodule

bind sfsr_top sfsr_top_chk #(.TW_CYCLES(TW_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .miso_oe(spi_miso_oe),
   .wr_start(wr_start), .status(status));

// File: tb/sfsr_top_tb.sv
module sfsr_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int TW         = 2000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic csn = 1'b1, sck = 1'b0, mosi = 1'b0;
   logic miso, miso_oe;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] mon_byte;
   int         mon_bits;

   always #(CLK_PERIOD/2) clk = ~clk;

   sfsr_top #(.TW_CYCLES(TW), .SYNC_STAGES(2), .PROTECT_MASK(16'h8403)) u_dut (
      .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sck(sck), .spi_mosi(mosi),
      .spi_miso(miso), .spi_miso_oe(miso_oe));

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Monitor: collects bytes while the output enable is high and compares with the queue
   always @(posedge sck) begin
      if (miso_oe) begin
         mon_byte = {mon_byte[6:0], miso};
         mon_bits++;
         if (mon_bits == 8) begin
            mon_bits = 0;
            if (exp_q.size() == 0) check("unexpected byte", {8'h0, mon_byte}, 16'hFFFF);
            else check(tag_q.pop_front(), {8'h0, mon_byte}, {8'h0, exp_q.pop_front()});
         end
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(input logic [31:0] val, input int n, input string req);
      for (int i = n - 1; i >= 0; i--) begin
         mosi = val[i];
         wait_clk(HALF);
         sck = 1'b1;
         wait_clk(HALF);
         sck = 1'b0;
      end
   endtask

   // Full command: opcode plus n data bits; OE must stay low during opcode (R4)
   task automatic cmd(input logic [7:0] op, input logic [15:0] data, input int n);
      csn = 1'b0;
      wait_clk(HALF);
      for (int i = 7; i >= 0; i--) begin
         mosi = op[i];
         wait_clk(HALF);
         if (i == 0) check("R4 oe low in opcode", {15'h0, miso_oe}, 16'h0);
         sck = 1'b1;
         wait_clk(HALF);
         sck = 1'b0;
      end
      if (n > 0) send_bits({16'h0, data}, n, "data");
      wait_clk(HALF);
      csn = 1'b1;
      wait_clk(4 * HALF);
   endtask

   // Driver: pushes expected bytes, then clocks them out
   task automatic rd(input logic [7:0] op, input logic [7:0] e0, input int nbytes, input string req);
      mon_bits = 0;
      for (int b = 0; b < nbytes; b++) begin
         exp_q.push_back(e0);
         tag_q.push_back(req);
      end
      csn = 1'b0;
      wait_clk(HALF);
      send_bits({24'h0, op}, 8, req);
      send_bits(32'h0, 8 * nbytes, req);
      wait_clk(HALF);
      csn = 1'b1;
      wait_clk(4 * HALF);
      check({req, " all bytes seen"}, 16'(exp_q.size()), 16'h0);
      exp_q.delete();
      tag_q.delete();
      check("R4 oe low after deselect", {15'h0, miso_oe}, 16'h0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      mon_byte = '0;
      mon_bits = 0;
      wait_clk(5);
      check("R1 oe in reset", {15'h0, miso_oe}, 16'h0);
      rst_n = 1'b1;
      wait_clk(5);
      // R1: reset status
      rd(8'h05, 8'h00, 1, "R1 R2 low byte after reset");
      rd(8'h35, 8'h00, 1, "R1 R3 high byte after reset");
      // R5: write without latch rejected
      cmd(8'h01, 16'h00FF, 8);
      wait_clk(20);
      rd(8'h05, 8'h00, 1, "R5 write without latch");
      // R5: enable sets latch
      cmd(8'h06, 16'h0, 0);
      rd(8'h05, 8'h02, 1, "R5 latch set by 06");
      // R6/R7/R9: 8-bit write of FF, protected bits 1,0 not from data
      cmd(8'h01, 16'h00FF, 8);
      rd(8'h05, 8'hFF, 1, "R9 busy during write");
      rd(8'h35, 8'h00, 1, "R6 8-bit write leaves high byte");
      wait_clk(TW + 50);
      rd(8'h05, 8'hFC, 1, "R10 R7 low byte after cycle");
      // R6/R7: 16-bit write, first byte 00 -> low, second FF -> high, bits 15,10 protected
      cmd(8'h06, 16'h0, 0);
      cmd(8'h01, 16'h00FF, 16);
      rd(8'h35, 8'h7B, 1, "R6 R7 high byte from second data byte");
      rd(8'h05, 8'h03, 1, "R6 low byte from first data byte");
      wait_clk(TW + 50);
      rd(8'h05, 8'h00, 1, "R10 latch cleared");
      // R8: bad bit count leaves everything, latch kept
      cmd(8'h06, 16'h0, 0);
      cmd(8'h01, 16'h0FFF, 12);
      wait_clk(20);
      rd(8'h05, 8'h02, 1, "R8 12-bit write aborted low");
      rd(8'h35, 8'h7B, 1, "R8 12-bit write aborted high");
      // R8: the kept latch still allows a valid write; R4 continuous repeat during busy
      cmd(8'h01, 16'h00A5, 8);
      rd(8'h05, 8'hA7, 2, "R4 R9 repeated byte while busy");
      wait_clk(TW + 50);
      rd(8'h05, 8'hA4, 1, "R10 after second write");
      // R5 via 50h, R11 commands ignored while busy
      cmd(8'h50, 16'h0, 0);
      cmd(8'h01, 16'h0000, 16);
      rd(8'h05, 8'h03, 1, "R5 R9 write after 50h");
      cmd(8'h06, 16'h0, 0);
      cmd(8'h01, 16'h00FC, 8);
      wait_clk(TW + 50);
      rd(8'h05, 8'h00, 1, "R11 enable and write ignored while busy");
      rd(8'h35, 8'h00, 1, "R11 high byte after busy");
      // R4: unknown opcode gives no output enable
      csn = 1'b0;
      wait_clk(HALF);
      send_bits(32'h9F00, 16, "R4");
      check("R4 oe low for other opcode", {15'h0, miso_oe}, 16'h0);
      csn = 1'b1;
      wait_clk(4 * HALF);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule